// File: doc/BRIEF.md
# On-chip versus off-chip memory region decoder

This block looks at every physical address issued by the processor and decides whether the access belongs to one of five on-chip memory regions or to the external memory port. For an on-chip hit it raises exactly one region select and releases the external port: the write and output strobes and the 8-bit external data bus are left undriven. Every address that no present and enabled on-chip region claims goes to the external port, where the active-low strobes follow the processor strobes and the write data is driven out.

Three of the regions can be turned off while the chip runs. Two configuration bits control program RAM and program ROM, and a bit in a power-management register controls text RAM. A region that is switched off is decoded as external, so external memory placed at the same addresses becomes reachable. When an enabled on-chip region and external memory cover the same address, the on-chip region always takes the access. An emulation input keeps the external drivers switched on during on-chip accesses so that a probe can follow the bus. The logic is purely combinational and holds no state.

Top module: `memdec_top`

## Requirements
- R1: The on-chip windows are program RAM 0x000000–0x000FFF (sel_int_o bit 0), I/O registers 0x001E00–0x001FFF (bit 1), boot ROM 0x002000–0x0023FF (bit 2), program ROM 0x002400–0x019FFF (bit 3) and text RAM 0x0A0000–0x0A3FFF (bit 4). While a strobe is active, an address inside an enabled window raises only that bit.
- R2: While a strobe is active, an address outside every enabled window raises sel_ext_o and leaves sel_int_o at zero.
- R3: While rd_i or wr_i is high, exactly one of the six selects (the five sel_int_o bits and sel_ext_o) is high. While both strobes are low, all six are low.
- R4: With pram_off_i high, program RAM addresses select external. The other windows are unaffected.
- R5: With prom_off_i high, program ROM addresses select external. Boot ROM and I/O stay on-chip.
- R6: With tram_off_i high, text RAM addresses select external.
- R7: During an on-chip access with emu_drive_i low, ext_ctl_oe_o and ext_data_oe_o are 0, ext_we_n_o and ext_oe_n_o are 1, and ext_data_o is zero.
- R8: During an external access, ext_ctl_oe_o is 1, ext_we_n_o equals the inverse of wr_i, ext_oe_n_o equals the inverse of rd_i, and ext_data_oe_o equals wr_i. While ext_data_oe_o is 1, ext_data_o carries wdata_i.
- R9: With emu_drive_i high, ext_ctl_oe_o stays 1 during on-chip accesses and the strobes stay inactive (1). During an on-chip write, ext_data_oe_o is 1 and ext_data_o carries wdata_i.
- R10: With no strobe active, ext_ctl_oe_o is 1, both strobe outputs are 1 and ext_data_oe_o is 0, whatever the value of emu_drive_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 24 | Physical address |
| rd_i | input | 1 | Processor read strobe, active high |
| wr_i | input | 1 | Processor write strobe, active high |
| wdata_i | input | 8 | Processor write data |
| pram_off_i | input | 1 | Configuration bit that turns off on-chip program RAM |
| prom_off_i | input | 1 | Configuration bit that turns off on-chip program ROM |
| tram_off_i | input | 1 | Power-management bit that turns off on-chip text RAM |
| emu_drive_i | input | 1 | Emulation mode: keep the external drivers on |
| sel_int_o | output | 5 | One-hot on-chip region select |
| sel_ext_o | output | 1 | External memory select |
| ext_we_n_o | output | 1 | External write enable, active low |
| ext_oe_n_o | output | 1 | External output enable, active low |
| ext_ctl_oe_o | output | 1 | Driver enable for the two external strobes |
| ext_data_o | output | 8 | Value driven onto the external data bus |
| ext_data_oe_o | output | 1 | Driver enable for the external data bus |

## Verification
Two functions can act in the same cycle: an on-chip region select and the emulation override of the external drivers. The bench raises emu_drive_i during on-chip reads and writes, for example a boot ROM write. It then expects the single on-chip select, strobes that stay inactive, and the write data on a driven bus. A region disable and an access at that region's boundary also coincide: for every combination of the three disable bits, the bench sweeps the first and last byte of each window and the bytes just outside it, and checks that ownership moves to external exactly where a window is switched off.

// File: rtl/memdec_pkg.sv
package memdec_pkg;
  localparam int ADDR_W = 24;
  localparam int NREG   = 5;

  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum int {
    RG_PRAM = 0,
    RG_IO   = 1,
    RG_BOOT = 2,
    RG_PROM = 3,
    RG_TRAM = 4
  } region_e;

  // Inclusive window bounds, indexed by region_e.
  localparam addr_t RG_LO [NREG] = '{24'h000000, 24'h001E00, 24'h002000,
                                     24'h002400, 24'h0A0000};
  localparam addr_t RG_HI [NREG] = '{24'h000FFF, 24'h001FFF, 24'h0023FF,
                                     24'h019FFF, 24'h0A3FFF};

  // Inclusive window test.
  function automatic logic addr_in(addr_t a, addr_t lo, addr_t hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // Per-region enable vector built from the three run-time switches.
  function automatic logic [NREG-1:0] build_enable(logic pram_off,
                                                   logic prom_off,
                                                   logic tram_off);
    logic [NREG-1:0] en;
    en          = '1;
    en[RG_PRAM] = ~pram_off;
    en[RG_PROM] = ~prom_off;
    en[RG_TRAM] = ~tram_off;
    return en;
  endfunction
endpackage

// File: rtl/memdec_match.sv
module memdec_match
  import memdec_pkg::*;
(
  input  addr_t           addr_i,
  input  logic [NREG-1:0] en_i,
  output logic [NREG-1:0] hit_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_win
    assign hit_o[g] = en_i[g] & addr_in(addr_i, RG_LO[g], RG_HI[g]);
  end
endmodule

// File: rtl/memdec_extport.sv
module memdec_extport #(
  parameter int DATA_W = 8
) (
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              int_i,
  input  logic              emu_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              sel_ext_o,
  output logic              we_n_o,
  output logic              oe_n_o,
  output logic              ctl_oe_o,
  output logic              data_oe_o,
  output logic [DATA_W-1:0] data_o
);
  logic strobe;
  logic ext_acc;
  logic int_acc;

  assign strobe    = rd_i | wr_i;
  assign ext_acc   = strobe & ~int_i;
  assign int_acc   = strobe & int_i;

  assign sel_ext_o = ext_acc;
  assign we_n_o    = ~(wr_i & ext_acc);
  assign oe_n_o    = ~(rd_i & ext_acc);
  // Strobe drivers are released only while an on-chip access runs.
  assign ctl_oe_o  = ~int_acc | emu_i;
  assign data_oe_o = wr_i & (ext_acc | emu_i);
  assign data_o    = data_oe_o ? wdata_i : '0;
endmodule

// File: rtl/memdec_top.sv
module memdec_top
  import memdec_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pram_off_i,
  input  logic              prom_off_i,
  input  logic              tram_off_i,
  input  logic              emu_drive_i,
  output logic [NREG-1:0]   sel_int_o,
  output logic              sel_ext_o,
  output logic              ext_we_n_o,
  output logic              ext_oe_n_o,
  output logic              ext_ctl_oe_o,
  output logic [DATA_W-1:0] ext_data_o,
  output logic              ext_data_oe_o
);
  logic [NREG-1:0] region_en;
  logic [NREG-1:0] region_hit;
  logic            int_hit;
  logic            strobe;

  assign region_en = build_enable(pram_off_i, prom_off_i, tram_off_i);
  assign strobe    = rd_i | wr_i;

  memdec_match u_match (
    .addr_i (addr_i),
    .en_i   (region_en),
    .hit_o  (region_hit)
  );

  // On-chip hit wins over external memory at the same address.
  assign int_hit   = |region_hit;
  assign sel_int_o = strobe ? region_hit : '0;

  memdec_extport #(.DATA_W(DATA_W)) u_ext (
    .rd_i      (rd_i),
    .wr_i      (wr_i),
    .int_i     (int_hit),
    .emu_i     (emu_drive_i),
    .wdata_i   (wdata_i),
    .sel_ext_o (sel_ext_o),
    .we_n_o    (ext_we_n_o),
    .oe_n_o    (ext_oe_n_o),
    .ctl_oe_o  (ext_ctl_oe_o),
    .data_oe_o (ext_data_oe_o),
    .data_o    (ext_data_o)
  );
endmodule

// File: rtl/memdec_chk.sv
module memdec_chk
  import memdec_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              pram_off_i,
  input logic              prom_off_i,
  input logic              tram_off_i,
  input logic              emu_drive_i,
  input logic [NREG-1:0]   region_hit,
  input logic [NREG-1:0]   sel_int_o,
  input logic              sel_ext_o,
  input logic              ext_we_n_o,
  input logic              ext_oe_n_o,
  input logic              ext_ctl_oe_o,
  input logic [DATA_W-1:0] ext_data_o,
  input logic              ext_data_oe_o
);
  always_comb begin
    // R1: the region windows never overlap
    assert_disjoint_R1: assert ($onehot0(region_hit))
      else $error("overlapping region hits");
    // R1: an I/O select implies the address lies in the I/O window
    if (sel_int_o[RG_IO])
      assert_io_window_R1: assert (addr_i[ADDR_W-1:9] == 15'h000F)
        else $error("I/O select outside its window");
    if (rd_i | wr_i)
      assert_one_select_R3: assert ($countones({sel_ext_o, sel_int_o}) == 1)
        else $error("select count wrong during access");
    else
      assert_idle_quiet_R3: assert (!sel_ext_o && sel_int_o == '0)
        else $error("select active while idle");
    if (pram_off_i)
      assert_pram_off_R4: assert (!sel_int_o[RG_PRAM])
        else $error("disabled program RAM selected");
    if (prom_off_i)
      assert_prom_off_R5: assert (!sel_int_o[RG_PROM])
        else $error("disabled program ROM selected");
    if (tram_off_i)
      assert_tram_off_R6: assert (!sel_int_o[RG_TRAM])
        else $error("disabled text RAM selected");
    if ((sel_int_o != '0) && !emu_drive_i)
      assert_released_R7: assert (!ext_ctl_oe_o && !ext_data_oe_o)
        else $error("external drivers on during on-chip access");
    if (!ext_we_n_o)
      assert_we_ext_R8: assert (sel_ext_o && wr_i)
        else $error("write strobe without external write");
    if (!ext_oe_n_o)
      assert_oe_ext_R8: assert (sel_ext_o && rd_i)
        else $error("output enable without external read");
    if (ext_data_oe_o)
      assert_data_val_R8: assert (ext_data_o == wdata_i)
        else $error("driven data differs from write data");
    if (emu_drive_i)
      assert_emu_drive_R9: assert (ext_ctl_oe_o)
        else $error("emulation lost strobe drivers");
  end
endmodule

bind memdec_top memdec_chk #(.DATA_W(DATA_W)) u_chk (
  .addr_i        (addr_i),
  .rd_i          (rd_i),
  .wr_i          (wr_i),
  .wdata_i       (wdata_i),
  .pram_off_i    (pram_off_i),
  .prom_off_i    (prom_off_i),
  .tram_off_i    (tram_off_i),
  .emu_drive_i   (emu_drive_i),
  .region_hit    (region_hit),
  .sel_int_o     (sel_int_o),
  .sel_ext_o     (sel_ext_o),
  .ext_we_n_o    (ext_we_n_o),
  .ext_oe_n_o    (ext_oe_n_o),
  .ext_ctl_oe_o  (ext_ctl_oe_o),
  .ext_data_o    (ext_data_o),
  .ext_data_oe_o (ext_data_oe_o)
);

// File: tb/tb_memdec_top.sv
module tb_memdec_top;
  localparam int NV  = 18;
  localparam int EXT = 7;   // expected-region code for external

  // {address, region code with all windows enabled}
  localparam logic [26:0] VEC [NV] = '{
    {24'h000000, 3'd0}, {24'h000FFF, 3'd0}, {24'h001000, 3'd7},
    {24'h001DFF, 3'd7}, {24'h001E00, 3'd1}, {24'h001FFF, 3'd1},
    {24'h002000, 3'd2}, {24'h0023FF, 3'd2}, {24'h002400, 3'd3},
    {24'h019FFF, 3'd3}, {24'h01A000, 3'd7}, {24'h09FFFF, 3'd7},
    {24'h0A0000, 3'd4}, {24'h0A3FFF, 3'd4}, {24'h0A4000, 3'd7},
    {24'hFFFFFF, 3'd7}, {24'h00FFF9, 3'd3}, {24'h00FFFE, 3'd3}
  };

  logic        clk = 1'b0;
  logic [23:0] addr;
  logic        rd, wr, poff, roff, toff, emu;
  logic [7:0]  wdata;
  logic [4:0]  sel_int;
  logic        sel_ext, we_n, oe_n, ctl_oe, data_oe;
  logic [7:0]  data;
  int          checks = 0;
  int          errors = 0;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  memdec_top dut (
    .addr_i(addr), .rd_i(rd), .wr_i(wr), .wdata_i(wdata),
    .pram_off_i(poff), .prom_off_i(roff), .tram_off_i(toff),
    .emu_drive_i(emu), .sel_int_o(sel_int), .sel_ext_o(sel_ext),
    .ext_we_n_o(we_n), .ext_oe_n_o(oe_n), .ext_ctl_oe_o(ctl_oe),
    .ext_data_o(data), .ext_data_oe_o(data_oe)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(logic [23:0] a, logic r, logic w, logic [7:0] d, logic e);
    @(posedge clk);
    addr = a; rd = r; wr = w; wdata = d; emu = e;
    @(negedge clk);
  endtask

  initial begin
    addr = '0; rd = 0; wr = 0; wdata = '0; poff = 0; roff = 0; toff = 0; emu = 0;
    @(negedge clk);
    // Idle state: R3 and R10
    chk("R3", "idle sel_int", 32'(sel_int), 0);
    chk("R3", "idle sel_ext", 32'(sel_ext), 0);
    chk("R10", "idle ctl_oe", 32'(ctl_oe), 1);
    chk("R10", "idle strobes", 32'({we_n, oe_n}), 3);
    chk("R10", "idle data_oe", 32'(data_oe), 0);

    // Boundary sweep under every disable combination
    for (int m = 0; m < 8; m++) begin
      poff = m[0]; roff = m[1]; toff = m[2];
      for (int v = 0; v < NV; v++) begin
        for (int w = 0; w < 2; w++) begin
          logic [2:0] base, expr;
          logic       in_int;
          string      tg, bt;
          base = VEC[v][2:0];
          expr = base;
          if (base == 3'd0 && m[0]) expr = EXT;
          if (base == 3'd3 && m[1]) expr = EXT;
          if (base == 3'd4 && m[2]) expr = EXT;
          in_int = (expr != EXT);
          if (in_int) tg = "R1";
          else if (base == EXT) tg = "R2";
          else if (base == 3'd0) tg = "R4";
          else if (base == 3'd3) tg = "R5";
          else tg = "R6";
          bt = in_int ? "R7" : "R8";
          drive(VEC[v][26:3], w == 0, w == 1, 8'(8'h3C + v), 1'b0);
          chk(tg, "sel_int", 32'(sel_int), in_int ? (32'd1 << expr) : 0);
          chk(tg, "sel_ext", 32'(sel_ext), in_int ? 0 : 1);
          chk(bt, "ctl_oe", 32'(ctl_oe), in_int ? 0 : 1);
          chk(bt, "we_n", 32'(we_n), (!in_int && w == 1) ? 0 : 1);
          chk(bt, "oe_n", 32'(oe_n), (!in_int && w == 0) ? 0 : 1);
          chk(bt, "data_oe", 32'(data_oe), (!in_int && w == 1) ? 1 : 0);
          chk(bt, "data", 32'(data), (!in_int && w == 1) ? 32'(8'h3C + v) : 0);
        end
      end
    end
    poff = 0; roff = 0; toff = 0;

    // R9: emulation keeps drivers on during an on-chip write to boot ROM
    drive(24'h002100, 1'b0, 1'b1, 8'hA5, 1'b1);
    chk("R9", "emu sel_int", 32'(sel_int), 32'h4);
    chk("R9", "emu ctl_oe", 32'(ctl_oe), 1);
    chk("R9", "emu strobes", 32'({we_n, oe_n}), 3);
    chk("R9", "emu data_oe", 32'(data_oe), 1);
    chk("R9", "emu data", 32'(data), 32'hA5);
    // R9: emulation during an on-chip read of text RAM
    drive(24'h0A1234, 1'b1, 1'b0, 8'h5A, 1'b1);
    chk("R9", "emu rd sel_int", 32'(sel_int), 32'h10);
    chk("R9", "emu rd ctl_oe", 32'(ctl_oe), 1);
    chk("R9", "emu rd data_oe", 32'(data_oe), 0);
    chk("R9", "emu rd oe_n", 32'(oe_n), 1);
    // R8 with emulation on: external write still strobes normally
    drive(24'h300000, 1'b0, 1'b1, 8'hC3, 1'b1);
    chk("R8", "emu ext we_n", 32'(we_n), 0);
    chk("R8", "emu ext data", 32'(data), 32'hC3);
    // R10: idle with emulation on
    drive(24'h000010, 1'b0, 1'b0, 8'hFF, 1'b1);
    chk("R10", "idle emu strobes", 32'({we_n, oe_n}), 3);
    chk("R10", "idle emu data_oe", 32'(data_oe), 0);
    chk("R3", "idle emu sel", 32'({sel_ext, sel_int}), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule